// File: doc/BRIEF.md
# SPI Serial Clock Rate Generator

This block derives the serial bit clock of an SPI master from a faster peripheral clock. The clock ratio can be set in one of two ways. In fine mode the ratio is an even prescale value multiplied by a second divider. In coarse mode the ratio is a power of two. The block drives the clock level and two single-cycle strobes that mark each rising and each falling edge, so that a neighbouring shift register can move data on those edges without detecting edges itself.

Software writes a configuration made of a mode bit, a prescale byte, a control word whose upper byte is the rate field, and a 3-bit exponent. It then raises the enable input. The clock is low while the block is disabled. The first rising edge follows after one half-period. Configuration written during operation is taken up only at the end of a full clock period. A period ends at a falling edge, so no clock phase is ever cut short.

Top module: `sck_rate_gen`

## Requirements
- R1: In fine mode one full SCK period lasts `Peff * (RATE + 1)` input clock cycles. RATE is `ctrl_word_i[15:8]`. Bits `ctrl_word_i[7:0]` have no effect on the output.
- R2: The rate field value N divides by N+1. Value 0 gives a second-stage ratio of 1, and value 255 gives a ratio of 256.
- R3: The effective prescale Peff is the prescale input with bit 0 cleared. Any value below 2 is replaced by 2. Peff is therefore always even and lies in the range 2 to 254.
- R4: In coarse mode (`mode_coarse_i` = 1) one SCK period lasts `2^(E+1)` cycles, where E is `pow_exp_i` in the range 0 to 7. This gives eight ratios from 2 to 256. In this mode the prescale and rate inputs have no effect.
- R5: SCK spends exactly half of each period high and half low.
- R6: A configuration change takes effect only at the next falling edge of SCK, which ends the period. The remainder of the running period and any phase already in progress keep the old timing.
- R7: While `enable_i` is low, SCK is low, no strobes are emitted and the internal count is cleared. After `enable_i` rises, the first rising edge of SCK comes exactly one half-period later.
- R8: `lead_o` is high for exactly the one cycle in which SCK has just risen. `trail_o` is high for exactly the one cycle in which SCK has just fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enable_i | input | 1 | Runs the clock when high |
| mode_coarse_i | input | 1 | 0 selects fine mode, 1 selects power-of-two mode |
| prescale_i | input | 8 | First-stage even prescale value |
| ctrl_word_i | input | 16 | Control word; bits 15:8 hold the rate field |
| pow_exp_i | input | 3 | Exponent E for coarse mode (ratio 2^(E+1)) |
| sck_o | output | 1 | Serial clock level |
| lead_o | output | 1 | Rising-edge strobe |
| trail_o | output | 1 | Falling-edge strobe |

## Verification
The clock level and both strobes come from registers that are updated on the same edge. Take enable rising as the start, and call the half-period H. The first `lead_o` then shows at the H-th falling-edge sample of the input clock. Each following strobe comes H samples after the one before it. The bench samples on the falling edge of the input clock and counts the samples between strobes. Each count is compared with H, which the bench computes from the requirement formulas. When enable drops, SCK must already read low at the first sample that follows. For a configuration written straight after a rising strobe, the next falling strobe is still due after the old H, and the next rising strobe after the new H.

// File: rtl/sck_pkg.sv
`timescale 1ns/1ps
package sck_pkg;
  typedef enum logic {
    DIV_FINE   = 1'b0,
    DIV_COARSE = 1'b1
  } div_mode_e;
endpackage

// File: rtl/sck_rst_sync.sv
`timescale 1ns/1ps
module sck_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/sck_half_calc.sv
`timescale 1ns/1ps
module sck_half_calc
  import sck_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8,
  parameter int EXP_W  = 3,
  parameter int CNT_W  = PRE_W - 1 + RATE_W + 1
) (
  input  div_mode_e          mode_i,
  input  logic [PRE_W-1:0]   prescale_i,
  input  logic [RATE_W-1:0]  rate_i,
  input  logic [EXP_W-1:0]   pow_exp_i,
  output logic [CNT_W-1:0]   half_o
);
  logic [PRE_W-1:0] pre_even;
  logic [PRE_W-1:0] pre_eff;
  logic [CNT_W-1:0] fine_half;
  logic [CNT_W-1:0] coarse_half;

  always_comb begin
    pre_even = {prescale_i[PRE_W-1:1], 1'b0};
    pre_eff  = (pre_even < PRE_W'(2)) ? PRE_W'(2) : pre_even;
  end

  // half of Peff*(rate+1); Peff is even so this division is exact
  assign fine_half   = CNT_W'(pre_eff[PRE_W-1:1]) * (CNT_W'(rate_i) + CNT_W'(1));
  assign coarse_half = CNT_W'(1) << pow_exp_i;

  generate
    if (CNT_W < (1 << EXP_W)) begin : g_bad_width
      initial $error("counter width too small for coarse exponent range");
    end
  endgenerate

  assign half_o = (mode_i == DIV_COARSE) ? coarse_half : fine_half;
endmodule

// File: rtl/sck_half_counter.sv
`timescale 1ns/1ps
module sck_half_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign wrap_o = run_i && (cnt_q == half_i - CNT_W'(1));

  always_comb begin
    if (!run_i || wrap_o) cnt_d = '0;
    else                  cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R5: the count never passes the half-period it is timing
  p_cnt_in_half_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < half_i);

  // R7: a stopped counter stays cleared
  p_cnt_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/sck_rate_gen.sv
`timescale 1ns/1ps
module sck_rate_gen
  import sck_pkg::*;
#(
  parameter int PRE_W    = 8,
  parameter int RATE_W   = 8,
  parameter int EXP_W    = 3,
  parameter int CTRL_W   = 16,
  parameter int RATE_LSB = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              mode_coarse_i,
  input  logic [PRE_W-1:0]  prescale_i,
  input  logic [CTRL_W-1:0] ctrl_word_i,
  input  logic [EXP_W-1:0]  pow_exp_i,
  output logic              sck_o,
  output logic              lead_o,
  output logic              trail_o
);
  localparam int CNT_W = PRE_W - 1 + RATE_W + 1;

  logic             rst_n_s;
  logic [CNT_W-1:0] half_new;
  logic [CNT_W-1:0] half_q, half_d;
  logic             sck_q, sck_d;
  logic             lead_q, lead_d;
  logic             trail_q, trail_d;
  logic             wrap;
  logic             unused_ctrl_low;
  div_mode_e        mode;

  assign unused_ctrl_low = ^ctrl_word_i[RATE_LSB-1:0];
  assign mode = div_mode_e'(mode_coarse_i);

  sck_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  sck_half_calc #(
    .PRE_W(PRE_W), .RATE_W(RATE_W), .EXP_W(EXP_W), .CNT_W(CNT_W)
  ) u_calc (
    .mode_i     (mode),
    .prescale_i (prescale_i),
    .rate_i     (ctrl_word_i[RATE_LSB +: RATE_W]),
    .pow_exp_i  (pow_exp_i),
    .half_o     (half_new)
  );

  sck_half_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .run_i  (enable_i),
    .half_i (half_q),
    .wrap_o (wrap)
  );

  // next state
  always_comb begin
    half_d  = half_q;
    sck_d   = sck_q;
    lead_d  = 1'b0;
    trail_d = 1'b0;
    if (!enable_i) begin
      half_d = half_new;
      sck_d  = 1'b0;
    end else if (wrap) begin
      sck_d   = ~sck_q;
      lead_d  = ~sck_q;
      trail_d = sck_q;
      if (sck_q) half_d = half_new;   // falling edge closes the period
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      half_q  <= CNT_W'(1);
      sck_q   <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      half_q  <= half_d;
      sck_q   <= sck_d;
      lead_q  <= lead_d;
      trail_q <= trail_d;
    end
  end

  assign sck_o   = sck_q;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;

  // R7: disabled means idle low and silent
  p_idle_low_r7: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !enable_i |=> (!sck_o && !lead_o && !trail_o));

  // R8: strobes coincide with real edges of the clock level
  p_lead_on_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    lead_o |-> (sck_o && !$past(sck_o)));
  p_trail_on_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    trail_o |-> (!sck_o && $past(sck_o)));
  p_lead_single_r8: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    lead_o |=> !lead_o);

  // R6: the active timing holds inside a running period
  p_cfg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (enable_i && !(wrap && sck_q)) |=> $stable(half_q));

  // R5: the active half-period is never zero
  p_half_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    half_q != '0);
endmodule

// File: tb/sck_rate_gen_bench.sv
`timescale 1ns/1ps
module sck_rate_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        coarse = 1'b0;
  logic [7:0]  pre = 8'd2;
  logic [15:0] ctrl = 16'h0000;
  logic [2:0]  pexp = 3'd0;
  logic        sck, lead, trail;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  sck_rate_gen u_sck_rate_gen (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .mode_coarse_i(coarse),
    .prescale_i(pre), .ctrl_word_i(ctrl), .pow_exp_i(pexp),
    .sck_o(sck), .lead_o(lead), .trail_o(trail)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int fine_half(input int p, input int r);
    int pe;
    pe = p & ~1;
    if (pe < 2) pe = 2;
    return (pe / 2) * (r + 1);
  endfunction

  // samples until the chosen strobe shows, counting samples taken
  task automatic count_to(input bit want_lead, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(want_lead ? lead : trail) && n < 70000);
  endtask

  task automatic stop_clock();
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_and_measure(input string req, input int h);
    int n;
    @(negedge clk);
    en = 1'b1;
    count_to(1'b1, n); chk({req, " first rise"}, n, h);
    chk({req, " sck high at lead"}, int'(sck), 1);
    count_to(1'b0, n); chk({req, " high phase"}, n, h);
    chk({req, " sck low at trail"}, int'(sck), 0);
    count_to(1'b1, n); chk({req, " low phase"}, n, h);
    stop_clock();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R7 reset sck", int'(sck), 0);
    chk("R8 reset strobes", int'(lead) + int'(trail), 0);
  endtask

  task automatic t_fine(input string req, input int p, input int r, input int lowb);
    coarse = 1'b0;
    pre = 8'(p);
    ctrl = {8'(r), 8'(lowb)};
    run_and_measure(req, fine_half(p, r));
  endtask

  task automatic t_coarse();
    for (int e = 0; e < 8; e++) begin
      coarse = 1'b1;
      pexp = 3'(e);
      pre = 8'd37;
      ctrl = 16'h5A5A;
      run_and_measure("R4 coarse", 1 << e);
    end
  endtask

  task automatic t_switch();
    int n;
    coarse = 1'b0; pre = 8'd4; ctrl = 16'h0200;   // H = 6
    @(negedge clk);
    en = 1'b1;
    count_to(1'b1, n); chk("R6 old rise", n, 6);
    pre = 8'd2; ctrl = 16'h0100;                  // H = 2
    count_to(1'b0, n); chk("R6 old high kept", n, 6);
    count_to(1'b1, n); chk("R6 new low", n, 2);
    count_to(1'b0, n); chk("R6 new high", n, 2);
    // change during low phase: low and high of this period stay new=2
    pre = 8'd8;                                   // H = 8
    count_to(1'b1, n); chk("R6 low kept", n, 2);
    count_to(1'b0, n); chk("R6 high kept", n, 2);
    count_to(1'b1, n); chk("R6 applied", n, 8);
    stop_clock();
  endtask

  task automatic t_disable();
    int n;
    int strobes;
    coarse = 1'b0; pre = 8'd6; ctrl = 16'h0000;   // H = 3
    @(negedge clk);
    en = 1'b1;
    count_to(1'b1, n);
    count_to(1'b0, n);
    @(negedge clk);                               // one cycle into low phase
    en = 1'b1;
    count_to(1'b1, n);                            // high again
    en = 1'b0;
    @(negedge clk);
    chk("R7 sck drops", int'(sck), 0);
    strobes = 0;
    for (int i = 0; i < 20; i++) begin
      if (lead || trail || sck) strobes++;
      @(negedge clk);
    end
    chk("R7 silent while off", strobes, 0);
    en = 1'b1;
    count_to(1'b1, n); chk("R7 restart after half", n, 3);
    count_to(1'b0, n); chk("R8 trail after restart", n, 3);
    stop_clock();
  endtask

  initial begin
    #1900000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fine("R1 fine 6x4", 6, 3, 0);
    t_fine("R1 low byte ignored", 6, 3, 8'hC3);
    t_fine("R5 fastest", 2, 0, 0);
    t_fine("R2 rate 255", 2, 255, 0);
    t_fine("R3 prescale 254", 254, 0, 0);
    t_fine("R3 odd prescale", 5, 1, 0);
    t_fine("R3 prescale zero", 0, 2, 0);
    t_fine("R3 prescale one", 1, 2, 0);
    t_coarse();
    t_switch();
    t_disable();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule